// File: doc/BRIEF.md
# Dual-Issue Integer/FP Pairing Controller

This block decides, every clock, which instructions of an in-order two-way machine may leave the decode stage. It receives a 64-bit fetch bundle that holds two 32-bit instruction words. The upper half (bits 63:32) is the left slot, which is meant for the integer pipe. The lower half (bits 31:0) is the right slot, which is meant for the FP pipe. The block decodes the operation class and the three register specifiers of both words. It checks them against results that are still in flight and against each other, then raises one issue strobe per slot.

Loads, including FP loads, travel down the integer pipe. An FP load in the left slot can therefore pair with an FP operation in the right slot. A load result cannot be used by the instruction that issues in the next cycle. An FP ALU result cannot be used during the two cycles after its producer issues. When only part of a bundle can go, the rest is kept inside the block and examined again on the next cycle, and no new bundle is taken until it has gone. A flush input drops everything the block is holding or tracking.

The instruction word is laid out as follows. Bits 31:30 hold the class: 0 integer ALU, 1 integer load, 2 FP load, 3 FP ALU. Bits 29:25 hold the destination, bits 24:20 source A and bits 19:15 source B. Bits 14:0 are not examined.

Which register file each specifier names depends on the class:

| Class | Source A | Source B | Destination |
|---|---|---|---|
| Integer ALU | integer | integer | integer |
| Integer load | integer (base) | not used | integer |
| FP load | integer (base) | not used | FP |
| FP ALU | FP | FP | FP |

Top module: `issue_pair_top`

## Requirements
- R1: Out of reset nothing is held: fetchReady is 1, and with fetchValid low no strobe is raised and issueCount is 0.
- R2: A fresh bundle with no hazard issues both words in the same cycle (issueCount 2). The left word must be of class 0, 1 or 2 and the right word of class 3. This includes an FP load on the left paired with an FP ALU operation on the right.
- R3: In any cycle where the left word of a bundle is still waiting and does not issue, the right word does not issue either, and both are kept.
- R4: If the left word is of class 3, or the right word is not of class 3, only the left word issues. The right word is kept and issues alone on the next cycle if it has no hazard.
- R5: If the right word reads, through source A or source B, the register that the left word of the same bundle writes, only the left word issues.
- R6: A word with a source equal to the destination of a load (class 1 in the integer file, class 2 in the FP file) does not issue in the cycle right after the load issued. It may issue two cycles after the load.
- R7: A word with a source equal to the destination of an FP ALU word does not issue in either of the two cycles after that producer issued. It may issue on the third cycle.
- R8: While a word is kept, fetchReady is 0 and the fetch inputs have no effect. The kept words issue before any new bundle is taken.
- R9: leftIssued and rightIssued flag the slots that issue, and issueCount gives their number in binary (0, 1 or 2).
- R10: In a cycle with flush high, no word issues. After that cycle, no word is kept, fetchReady is 1, and no earlier load or FP result stalls a later word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Drop kept words and all in-flight result tracking |
| fetchValid | input | 1 | fetchBundle carries a new bundle |
| fetchBundle | input | 64 | Left word in 63:32, right word in 31:0 |
| fetchReady | output | 1 | A new bundle is taken this cycle |
| leftIssued | output | 1 | Left-slot word issues this cycle |
| rightIssued | output | 1 | Right-slot word issues this cycle |
| issueCount | output | 2 | Number of words issued this cycle |
| leftInstrOut | output | 32 | Left-slot word under examination |
| rightInstrOut | output | 32 | Right-slot word under examination |

## Verification
The stimulus table sends several kinds of bundle, and each one isolates one rule:
- A clean integer/FP pair and an FP-load/FP-op pair exercise the full-width path.
- Bundles that mismatch slot types, in either direction, separate the slot-type rule from the dependence rules.
- A bundle whose FP-load destination feeds the right word separates the same-bundle check from the latency checks.
- Consumers placed one, two and three cycles after integer loads, FP loads and FP ALU producers show where each interlock releases.

A stalled left word shows that the right word waits with it. During a hold, the bench drives a bundle that would issue differently if it were taken, to show that the fetch input is ignored. Flush is exercised twice: once right after an FP producer, to prove the tracking is wiped, and once during a hold, to prove the kept words are dropped.

// File: rtl/issue_pair_pkg.sv
package issue_pair_pkg;

  localparam int INSTR_W   = 32;
  localparam int REG_IDX_W = 5;
  localparam int REG_ID_W  = REG_IDX_W + 1;   // file bit + index
  localparam int CLS_LO    = 30;
  localparam int DST_LO    = 25;
  localparam int SRCA_LO   = 20;
  localparam int SRCB_LO   = 15;

  typedef enum logic [1:0] {
    CLS_INT_ALU  = 2'd0,
    CLS_INT_LOAD = 2'd1,
    CLS_FP_LOAD  = 2'd2,
    CLS_FP_ALU   = 2'd3
  } opClass_e;

  typedef struct packed {
    opClass_e              cls;
    logic [REG_ID_W-1:0]   dst;
    logic [REG_ID_W-1:0]   srcA;
    logic [REG_ID_W-1:0]   srcB;
    logic                  useB;
  } decoded_t;

  // control -> datapath
  typedef struct packed {
    logic issueLeft;
    logic issueRight;
    logic discard;
  } issueStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic holdValid;
    logic leftPend;
    logic rightPend;
    logic leftBusy;
    logic rightBusy;
    logic slotTypeOk;
    logic pairDep;
  } hazardFlags_t;

  function automatic decoded_t decodeFields(input logic [1:0] clsBits,
                                            input logic [REG_IDX_W-1:0] d,
                                            input logic [REG_IDX_W-1:0] a,
                                            input logic [REG_IDX_W-1:0] b);
    decoded_t r;
    opClass_e c;
    c      = opClass_e'(clsBits);
    r.cls  = c;
    r.dst  = {(c == CLS_FP_LOAD) || (c == CLS_FP_ALU), d};
    r.srcA = {c == CLS_FP_ALU, a};
    r.srcB = {c == CLS_FP_ALU, b};
    r.useB = (c == CLS_INT_ALU) || (c == CLS_FP_ALU);
    return r;
  endfunction

endpackage

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
  import issue_pair_pkg::*;
#(
  parameter int LOAD_LAT  = 1,
  parameter int FPALU_LAT = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  clear,
  input  logic                  wrEnA,
  input  logic [REG_ID_W-1:0]   wrIdA,
  input  opClass_e              wrClsA,
  input  logic                  wrEnB,
  input  logic [REG_ID_W-1:0]   wrIdB,
  input  opClass_e              wrClsB,
  output logic [(1<<REG_ID_W)-1:0] busy
);

  localparam int NUM_REGS = 1 << REG_ID_W;
  localparam int MAX_LAT  = (LOAD_LAT > FPALU_LAT) ? LOAD_LAT : FPALU_LAT;
  localparam int CNT_W    = (MAX_LAT < 2) ? 1 : $clog2(MAX_LAT + 1);

  logic [CNT_W-1:0] latA, latB;

  always_comb begin
    unique case (wrClsA)
      CLS_INT_LOAD, CLS_FP_LOAD: latA = CNT_W'(LOAD_LAT);
      CLS_FP_ALU:                latA = CNT_W'(FPALU_LAT);
      default:                   latA = '0;
    endcase
    unique case (wrClsB)
      CLS_INT_LOAD, CLS_FP_LOAD: latB = CNT_W'(LOAD_LAT);
      CLS_FP_ALU:                latB = CNT_W'(FPALU_LAT);
      default:                   latB = '0;
    endcase
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [CNT_W-1:0] cnt;
    logic hitA, hitB;
    assign hitA = wrEnA && (wrIdA == REG_ID_W'(r)) && (latA != '0);
    assign hitB = wrEnB && (wrIdB == REG_ID_W'(r)) && (latB != '0);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            cnt <= '0;
      else if (clear)       cnt <= '0;
      else if (hitB)        cnt <= latB;     // later in program order wins
      else if (hitA)        cnt <= latA;
      else if (cnt != '0)   cnt <= cnt - CNT_W'(1);
    end
    assign busy[r] = (cnt != '0);
  end

endmodule

// File: rtl/issue_datapath.sv
module issue_datapath
  import issue_pair_pkg::*;
#(
  parameter int LOAD_LAT  = 1,
  parameter int FPALU_LAT = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  issueStrobe_t          strobe,
  input  logic                  fetchValid,
  input  logic [2*INSTR_W-1:0]  fetchBundle,
  output hazardFlags_t          flags,
  output logic [INSTR_W-1:0]    leftWord,
  output logic [INSTR_W-1:0]    rightWord
);

  localparam int NUM_REGS = 1 << REG_ID_W;

  logic               holdValid, heldLPend, heldRPend;
  logic [INSTR_W-1:0] heldL, heldR;
  logic [INSTR_W-1:0] curL, curR;
  logic               curLPend, curRPend;
  decoded_t           decL, decR;
  logic [NUM_REGS-1:0] busy;

  assign curL     = holdValid ? heldL     : fetchBundle[2*INSTR_W-1:INSTR_W];
  assign curR     = holdValid ? heldR     : fetchBundle[INSTR_W-1:0];
  assign curLPend = holdValid ? heldLPend : fetchValid;
  assign curRPend = holdValid ? heldRPend : fetchValid;

  assign decL = decodeFields(curL[CLS_LO+:2], curL[DST_LO+:REG_IDX_W],
                             curL[SRCA_LO+:REG_IDX_W], curL[SRCB_LO+:REG_IDX_W]);
  assign decR = decodeFields(curR[CLS_LO+:2], curR[DST_LO+:REG_IDX_W],
                             curR[SRCA_LO+:REG_IDX_W], curR[SRCB_LO+:REG_IDX_W]);

  always_comb begin
    flags.holdValid  = holdValid;
    flags.leftPend   = curLPend;
    flags.rightPend  = curRPend;
    flags.leftBusy   = busy[decL.srcA] || (decL.useB && busy[decL.srcB]);
    flags.rightBusy  = busy[decR.srcA] || (decR.useB && busy[decR.srcB]);
    flags.slotTypeOk = (decL.cls != CLS_FP_ALU) && (decR.cls == CLS_FP_ALU);
    flags.pairDep    = (decR.srcA == decL.dst) ||
                       (decR.useB && (decR.srcB == decL.dst));
  end

  assign leftWord  = curL;
  assign rightWord = curR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      heldLPend <= 1'b0;
      heldRPend <= 1'b0;
      heldL     <= '0;
      heldR     <= '0;
    end else if (strobe.discard) begin
      holdValid <= 1'b0;
      heldLPend <= 1'b0;
      heldRPend <= 1'b0;
    end else begin
      heldLPend <= curLPend && !strobe.issueLeft;
      heldRPend <= curRPend && !strobe.issueRight;
      holdValid <= (curLPend && !strobe.issueLeft) ||
                   (curRPend && !strobe.issueRight);
      heldL     <= curL;
      heldR     <= curR;
    end
  end

  issue_scoreboard #(
    .LOAD_LAT  (LOAD_LAT),
    .FPALU_LAT (FPALU_LAT)
  ) u_scoreboard (
    .clk    (clk),
    .rstN   (rstN),
    .clear  (strobe.discard),
    .wrEnA  (strobe.issueLeft),
    .wrIdA  (decL.dst),
    .wrClsA (decL.cls),
    .wrEnB  (strobe.issueRight),
    .wrIdB  (decR.dst),
    .wrClsB (decR.cls),
    .busy   (busy)
  );

endmodule

// File: rtl/issue_control.sv
module issue_control
  import issue_pair_pkg::*;
(
  input  logic          flush,
  input  hazardFlags_t  flags,
  output issueStrobe_t  strobe,
  output logic          fetchReady,
  output logic          leftIssued,
  output logic          rightIssued,
  output logic [1:0]    issueCount
);

  logic leftGo, rightGo, pairOk;

  assign leftGo  = flags.leftPend && !flags.leftBusy && !flush;
  assign pairOk  = flags.slotTypeOk && !flags.pairDep;
  // a right word that is the older one left over issues on its own hazards
  assign rightGo = flags.rightPend && !flags.rightBusy && !flush &&
                   (flags.leftPend ? (leftGo && pairOk) : 1'b1);

  always_comb begin
    strobe.issueLeft  = leftGo;
    strobe.issueRight = rightGo;
    strobe.discard    = flush;
  end

  assign fetchReady  = !flags.holdValid;
  assign leftIssued  = leftGo;
  assign rightIssued = rightGo;
  assign issueCount  = {leftGo && rightGo, leftGo ^ rightGo};

endmodule

// File: rtl/issue_pair_top.sv
module issue_pair_top
  import issue_pair_pkg::*;
#(
  parameter int LOAD_LAT  = 1,
  parameter int FPALU_LAT = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        flush,
  input  logic        fetchValid,
  input  logic [63:0] fetchBundle,
  output logic        fetchReady,
  output logic        leftIssued,
  output logic        rightIssued,
  output logic [1:0]  issueCount,
  output logic [31:0] leftInstrOut,
  output logic [31:0] rightInstrOut
);

  issueStrobe_t strobe;
  hazardFlags_t flags;

  issue_control u_control (
    .flush       (flush),
    .flags       (flags),
    .strobe      (strobe),
    .fetchReady  (fetchReady),
    .leftIssued  (leftIssued),
    .rightIssued (rightIssued),
    .issueCount  (issueCount)
  );

  issue_datapath #(
    .LOAD_LAT  (LOAD_LAT),
    .FPALU_LAT (FPALU_LAT)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .fetchValid  (fetchValid),
    .fetchBundle (fetchBundle),
    .flags       (flags),
    .leftWord    (leftInstrOut),
    .rightWord   (rightInstrOut)
  );

endmodule

// File: rtl/issue_pair_checker.sv
module issue_pair_checker (
  input logic        clk,
  input logic        rstN,
  input logic        flush,
  input logic        fetchValid,
  input logic        fetchReady,
  input logic        leftIssued,
  input logic        rightIssued,
  input logic [1:0]  issueCount,
  input logic [11:0] leftHead,    // class, dst, srcA of the left word
  input logic [11:0] rightHead
);

  // R10
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> (!leftIssued && !rightIssued));

  // R10
  flush_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> fetchReady);

  // R3
  right_after_left_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReady && fetchValid && rightIssued) |-> leftIssued);

  // R8
  leftover_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReady && fetchValid && !flush && !rightIssued) |=> !fetchReady);

  // R4
  pair_slot_type_chk: assert property (@(posedge clk) disable iff (!rstN)
    (leftIssued && rightIssued && fetchReady) |->
      ((leftHead[11:10] != 2'd3) && (rightHead[11:10] == 2'd3)));

  // R9
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueCount != 2'd3);

  // R6
  int_load_use_chk: assert property (@(posedge clk) disable iff (!rstN)
    (leftIssued && (leftHead[11:10] == 2'd1)) |=>
      !(leftIssued && (leftHead[11:10] != 2'd3) &&
        (leftHead[4:0] == $past(leftHead[9:5]))));

  // R7
  fp_alu_use_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rightIssued && (rightHead[11:10] == 2'd3)) |=>
      !(rightIssued && (rightHead[11:10] == 2'd3) &&
        (rightHead[4:0] == $past(rightHead[9:5]))));

endmodule

bind issue_pair_top issue_pair_checker u_issue_pair_checker (
  .clk         (clk),
  .rstN        (rstN),
  .flush       (flush),
  .fetchValid  (fetchValid),
  .fetchReady  (fetchReady),
  .leftIssued  (leftIssued),
  .rightIssued (rightIssued),
  .issueCount  (issueCount),
  .leftHead    (leftInstrOut[31:20]),
  .rightHead   (rightInstrOut[31:20])
);

// File: tb/issue_pair_top_bench.sv
module issue_pair_top_bench;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic        fetchValid = 1'b0;
  logic [63:0] fetchBundle = '0;
  logic        fetchReady, leftIssued, rightIssued;
  logic [1:0]  issueCount;
  logic [31:0] leftInstrOut, rightInstrOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  issue_pair_top u_issue_pair_top (
    .clk(clk), .rstN(rstN), .flush(flush), .fetchValid(fetchValid),
    .fetchBundle(fetchBundle), .fetchReady(fetchReady),
    .leftIssued(leftIssued), .rightIssued(rightIssued),
    .issueCount(issueCount), .leftInstrOut(leftInstrOut),
    .rightInstrOut(rightInstrOut)
  );

  // class: 0 int ALU, 1 int load, 2 FP load, 3 FP ALU
  function automatic logic [31:0] mk(input logic [1:0] c, input int d,
                                     input int a, input int b);
    logic [4:0] dd, aa, bb;
    dd = d[4:0]; aa = a[4:0]; bb = b[4:0];
    return {c, dd, aa, bb, 15'd0};
  endfunction

  typedef struct packed {
    logic        fv;
    logic [31:0] lw;
    logic [31:0] rw;
    logic        exL;
    logic        exR;
    logic        exRdy;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b1, mk(0,1,2,3),   mk(3,1,2,3),    1'b1,1'b1,1'b1, 4'd2}, // R2 clean pair
    '{1'b1, mk(0,4,5,6),   mk(3,4,1,2),    1'b1,1'b0,1'b1, 4'd7}, // R7 f1 one cycle old
    '{1'b0, 32'd0,         32'd0,          1'b0,1'b0,1'b0, 4'd7}, // R7 two cycles old
    '{1'b0, 32'd0,         32'd0,          1'b0,1'b1,1'b0, 4'd7}, // R7 released
    '{1'b1, mk(2,5,7,0),   mk(3,6,7,8),    1'b1,1'b1,1'b1, 4'd2}, // R2 FP load + FP op
    '{1'b1, mk(0,8,9,10),  mk(3,9,5,6),    1'b1,1'b0,1'b1, 4'd6}, // R6 f5 load t+1
    '{1'b0, 32'd0,         32'd0,          1'b0,1'b0,1'b0, 4'd7}, // R7 f6 still busy
    '{1'b0, 32'd0,         32'd0,          1'b0,1'b1,1'b0, 4'd7}, // R7 released
    '{1'b1, mk(2,10,1,0),  mk(3,11,10,12), 1'b1,1'b0,1'b1, 4'd5}, // R5 same-bundle RAW
    '{1'b0, 32'd0,         32'd0,          1'b0,1'b0,1'b0, 4'd6}, // R6 f10 t+1
    '{1'b0, 32'd0,         32'd0,          1'b0,1'b1,1'b0, 4'd6}, // R6 f10 t+2
    '{1'b1, mk(3,13,14,15),mk(3,16,17,18), 1'b1,1'b0,1'b1, 4'd4}, // R4 FP op on left
    '{1'b0, 32'd0,         32'd0,          1'b0,1'b1,1'b0, 4'd4}, // R4 leftover goes
    '{1'b1, mk(0,11,12,13),mk(0,14,15,16), 1'b1,1'b0,1'b1, 4'd4}, // R4 int op on right
    '{1'b0, 32'd0,         32'd0,          1'b0,1'b1,1'b0, 4'd4}, // R4 leftover goes
    '{1'b1, mk(1,17,18,0), mk(3,19,20,21), 1'b1,1'b1,1'b1, 4'd2}, // R2 int load pair
    '{1'b1, mk(0,20,17,1), mk(3,22,20,21), 1'b0,1'b0,1'b1, 4'd3}, // R3 left stalls
    '{1'b1, mk(3,25,26,27),mk(0,1,2,3),    1'b1,1'b1,1'b0, 4'd8}, // R8 fetch ignored
    '{1'b0, 32'd0,         32'd0,          1'b0,1'b0,1'b1, 4'd1}  // R1 idle
  };

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic fv, input logic [31:0] lw, input logic [31:0] rw,
                      input logic fl, input logic exL, input logic exR,
                      input logic exRdy, input string tag);
    @(negedge clk);
    fetchValid  = fv;
    fetchBundle = {lw, rw};
    flush       = fl;
    #1;
    chk(tag, "leftIssued", {31'd0, leftIssued}, {31'd0, exL});
    chk(tag, "rightIssued", {31'd0, rightIssued}, {31'd0, exR});
    chk("R9", "issueCount", {30'd0, issueCount}, {30'd0, exL & exR, exL ^ exR});
    chk(tag, "fetchReady", {31'd0, fetchReady}, {31'd0, exRdy});
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired (all requirements)");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    chk("R1", "fetchReady in reset", {31'd0, fetchReady}, 32'd1);
    chk("R1", "leftIssued in reset", {31'd0, leftIssued}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    step(1'b0, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R1");

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].fv, VEC[i].lw, VEC[i].rw, 1'b0,
           VEC[i].exL, VEC[i].exR, VEC[i].exRdy, $sformatf("R%0d", VEC[i].req));
    end

    // R10: flush wipes result tracking (f25 would still be busy)
    step(1'b1, mk(0,24,2,3),  mk(3,25,2,3),  1'b0, 1'b1, 1'b1, 1'b1, "R10");
    step(1'b1, mk(0,1,2,3),   mk(3,28,2,3),  1'b1, 1'b0, 1'b0, 1'b1, "R10");
    step(1'b1, mk(0,26,24,2), mk(3,26,25,1), 1'b0, 1'b1, 1'b1, 1'b1, "R10");
    // R10: flush drops kept words
    step(1'b1, mk(1,27,2,0),  mk(3,29,2,3),  1'b0, 1'b1, 1'b1, 1'b1, "R10");
    step(1'b1, mk(0,28,27,2), mk(3,30,2,3),  1'b0, 1'b0, 1'b0, 1'b1, "R3");
    step(1'b0, 32'd0, 32'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R10");
    step(1'b0, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R10");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule